// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block runs word-at-a-time sequential programming inside a serial flash slave. A command front end hands it already decoded opcode bytes, an assembled 24-bit address and individual data bytes, all as single-cycle strobes. The first auto-increment command (opcode ADh) carries a start address followed by two data bytes. Every later command of the same opcode carries only two data bytes, and those go to the next word.

For each word the block issues two byte-program requests toward the array, one after the other. The low byte goes to the even location and the high byte to the odd one. Each request is held until the array acknowledges it. While a word is in flight the block reports busy. Optionally it drives a ready/busy level on the serial data-out pin when chip-enable is low and no command is running. Leaving the mode also drops the write-enable latch.

Top module: `aai_word_seq`

## Requirements
- R1: After reset, `prog_req`, `busy`, `stat_aai`, `wel` and `so_oe` are all 0.
- R2: An ADh opcode is ignored when the write-enable latch is clear and the mode is not active. No program request follows, and `stat_aai` stays 0 even if address and data strobes come after it.
- R3: WREN (06h) sets `wel`. An ADh command then takes one address strobe and two data strobes, and produces two requests in order: first byte 0 at the word address with bit 0 = 0, then byte 1 with bit 0 = 1. Each request holds `prog_req`, `prog_addr` and `prog_data` steady until `prog_done` is sampled high.
- R4: In the mode, an ADh command takes exactly two data strobes and no address. It programs the word whose address is 2 above the previous word, with carry across all address bits.
- R5: `busy` is high from the cycle after the second data strobe until the cycle after the second acknowledge. While busy, ADh, WREN, WRDI and RDSR are ignored, and data strobes cause no programming.
- R6: When not busy, WRDI (04h) clears `wel` and leaves the mode. RDSR (05h) in the mode leaves the mode and clears `wel`. Both take effect in the cycle after the opcode strobe.
- R7: EBSY (70h) enables and DBSY (80h) disables the ready/busy output. When enabled, `so_oe` is high exactly when the mode is active, `cs_n` is low, and no opcode has been seen since `cs_n` last went high. In that case `so_out` = 1 when ready and 0 when busy.
- R8: `stat_aai` (status bit 6) rises in the cycle after the first command's second data strobe and stays high until the mode is left.
- R9: If `cs_n` goes high before the second data strobe of a command, the command is dropped. Nothing is programmed and the mode state does not change.
- R10: Bit 0 of the start address is ignored. The word starts at the address with bit 0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip-enable, active low |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 8 | Decoded opcode |
| addr_valid | input | 1 | Address strobe |
| addr | input | 24 | Assembled address |
| data_valid | input | 1 | Data byte strobe |
| data_in | input | 8 | Data byte |
| prog_done | input | 1 | Array acknowledge for the current byte |
| prog_req | output | 1 | Byte program request |
| prog_addr | output | 24 | Byte address of the request |
| prog_data | output | 8 | Byte value of the request |
| busy | output | 1 | Word programming in progress |
| stat_aai | output | 1 | Mode flag for status bit 6 |
| wel | output | 1 | Write-enable latch |
| so_oe | output | 1 | Data-out pin drive enable for ready/busy |
| so_out | output | 1 | Ready/busy level (1 = ready) |

## Verification
The bench starts from an odd address to catch a design that keeps bit 0, which would write byte 0 to the odd location. It crosses a 64 KiB boundary to expose an increment that drops the carry. It aborts a continuation halfway to catch a design that programs half a word or leaves the mode. It sends an ADh while busy, which a faulty design would take as a new word and so program stray data. It checks the pin drive both while busy and after DBSY, and it checks that RDSR and WRDI also clear the latch. A cycle-level model compares every output on every clock.

// File: rtl/aai_seq_pkg.sv
package aai_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_BYTE0,
        ST_BYTE1,
        ST_PROG0,
        ST_PROG1
    } seq_st_e;

    localparam logic [7:0] OP_AAI  = 8'hAD;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_EBSY = 8'h70;
    localparam logic [7:0] OP_DBSY = 8'h80;
endpackage

// File: rtl/aai_ctrl.sv
module aai_ctrl
    import aai_seq_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          op_valid,
    input  logic [7:0]    op_code,
    input  logic          addr_valid,
    input  logic [AW-1:0] addr,
    input  logic          data_valid,
    input  logic [DW-1:0] data_in,
    input  logic          prog_done,
    output logic          prog_req,
    output logic [AW-1:0] prog_addr,
    output logic [DW-1:0] prog_data,
    output logic          busy,
    output logic          aai_active,
    output logic          wel
);
    localparam int WW = AW - 1;

    typedef struct packed {
        seq_st_e       st;
        logic          aai;
        logic          wel;
        logic [WW-1:0] word;
        logic [DW-1:0] b0;
        logic [DW-1:0] b1;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        case (ctl_q.st)
            ST_IDLE: begin
                if (op_valid) begin
                    case (op_code)
                        OP_AAI: begin
                            if (ctl_q.aai)      ctl_d.st = ST_BYTE0;
                            else if (ctl_q.wel) ctl_d.st = ST_ADDR;
                        end
                        OP_WREN: ctl_d.wel = 1'b1;
                        OP_WRDI: begin
                            ctl_d.wel = 1'b0;
                            ctl_d.aai = 1'b0;
                        end
                        OP_RDSR: begin
                            if (ctl_q.aai) begin
                                ctl_d.aai = 1'b0;
                                ctl_d.wel = 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_ADDR: begin
                if (cs_n) ctl_d.st = ST_IDLE;
                else if (addr_valid) begin
                    ctl_d.word = addr[AW-1:1];
                    ctl_d.st   = ST_BYTE0;
                end
            end
            ST_BYTE0: begin
                if (cs_n) ctl_d.st = ST_IDLE;
                else if (data_valid) begin
                    ctl_d.b0 = data_in;
                    ctl_d.st = ST_BYTE1;
                end
            end
            ST_BYTE1: begin
                if (cs_n) ctl_d.st = ST_IDLE;
                else if (data_valid) begin
                    ctl_d.b1  = data_in;
                    ctl_d.aai = 1'b1;
                    ctl_d.st  = ST_PROG0;
                end
            end
            ST_PROG0: if (prog_done) ctl_d.st = ST_PROG1;
            ST_PROG1: begin
                if (prog_done) begin
                    ctl_d.word = ctl_q.word + 1'b1;
                    ctl_d.st   = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign prog_req   = (ctl_q.st == ST_PROG0) || (ctl_q.st == ST_PROG1);
    assign prog_addr  = {ctl_q.word, ctl_q.st == ST_PROG1};
    assign prog_data  = (ctl_q.st == ST_PROG1) ? ctl_q.b1 : ctl_q.b0;
    assign busy       = prog_req;
    assign aai_active = ctl_q.aai;
    assign wel        = ctl_q.wel;
endmodule

// File: rtl/aai_busy_pin.sv
module aai_busy_pin
    import aai_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       op_valid,
    input  logic [7:0] op_code,
    input  logic       aai_active,
    input  logic       busy,
    output logic       so_oe,
    output logic       so_out
);
    typedef struct packed {
        logic ebsy;
        logic in_cmd;
    } pin_t;

    pin_t pin_d, pin_q;

    always_comb begin
        pin_d = pin_q;
        if (op_valid && op_code == OP_EBSY)      pin_d.ebsy = 1'b1;
        else if (op_valid && op_code == OP_DBSY) pin_d.ebsy = 1'b0;
        if (cs_n)          pin_d.in_cmd = 1'b0;
        else if (op_valid) pin_d.in_cmd = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end

    assign so_oe  = pin_q.ebsy && aai_active && !cs_n && !pin_q.in_cmd;
    assign so_out = !busy;
endmodule

// File: rtl/aai_word_seq.sv
module aai_word_seq #(
    parameter int AW = 24,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          op_valid,
    input  logic [7:0]    op_code,
    input  logic          addr_valid,
    input  logic [AW-1:0] addr,
    input  logic          data_valid,
    input  logic [DW-1:0] data_in,
    input  logic          prog_done,
    output logic          prog_req,
    output logic [AW-1:0] prog_addr,
    output logic [DW-1:0] prog_data,
    output logic          busy,
    output logic          stat_aai,
    output logic          wel,
    output logic          so_oe,
    output logic          so_out
);
    aai_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .addr_valid (addr_valid),
        .addr       (addr),
        .data_valid (data_valid),
        .data_in    (data_in),
        .prog_done  (prog_done),
        .prog_req   (prog_req),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .busy       (busy),
        .aai_active (stat_aai),
        .wel        (wel)
    );

    aai_busy_pin u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .aai_active (stat_aai),
        .busy       (busy),
        .so_oe      (so_oe),
        .so_out     (so_out)
    );
endmodule

// File: rtl/aai_word_seq_chk.sv
module aai_word_seq_chk #(
    parameter int AW = 24,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          op_valid,
    input logic [7:0]    op_code,
    input logic          data_valid,
    input logic          prog_done,
    input logic          prog_req,
    input logic [AW-1:0] prog_addr,
    input logic [DW-1:0] prog_data,
    input logic          busy,
    input logic          stat_aai,
    input logic          wel,
    input logic          so_oe
);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req && !prog_done |=> prog_req && $stable(prog_addr) && $stable(prog_data));

    // R10
    even_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_req) |-> !prog_addr[0]);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !prog_done |=> busy);

    // R6
    wrdi_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 8'h04 && !busy |=> !wel && !stat_aai);

    // R7
    pin_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> stat_aai && !cs_n);

    // R8
    mode_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_aai) |-> $past(data_valid) && busy);
endmodule

bind aai_word_seq aai_word_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .data_valid (data_valid),
    .prog_done  (prog_done),
    .prog_req   (prog_req),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .busy       (busy),
    .stat_aai   (stat_aai),
    .wel        (wel),
    .so_oe      (so_oe)
);

// File: tb/test_aai_word_seq.sv
`timescale 1ns/1ps
module test_aai_word_seq;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cs_n = 1;
    logic        op_valid = 0;
    logic [7:0]  op_code = 0;
    logic        addr_valid = 0;
    logic [23:0] addr = 0;
    logic        data_valid = 0;
    logic [7:0]  data_in = 0;
    logic        prog_done = 0;
    logic        prog_req, busy, stat_aai, wel, so_oe, so_out;
    logic [23:0] prog_addr;
    logic [7:0]  prog_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    aai_word_seq i_aai_word_seq (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .op_valid(op_valid), .op_code(op_code),
        .addr_valid(addr_valid), .addr(addr), .data_valid(data_valid), .data_in(data_in),
        .prog_done(prog_done), .prog_req(prog_req), .prog_addr(prog_addr),
        .prog_data(prog_data), .busy(busy), .stat_aai(stat_aai), .wel(wel),
        .so_oe(so_oe), .so_out(so_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // array stub: acknowledges each byte after three cycles of request
    int lat_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prog_done <= 0;
            lat_cnt = 0;
        end else if (prog_req && !prog_done) begin
            lat_cnt++;
            if (lat_cnt == 3) begin
                prog_done <= 1;
                lat_cnt = 0;
            end
        end else prog_done <= 0;
    end

    // behavioural reference model
    int          m_ph = 0;  // 0 idle, 1 want addr, 2 want byte0, 3 want byte1, 4/5 writing
    bit          m_aai = 0, m_wel = 0, m_ebsy = 0, m_incmd = 0;
    logic [22:0] m_word = 0;
    logic [7:0]  m_b0 = 0, m_b1 = 0;
    logic [23:0] exp_a[$];
    logic [7:0]  exp_d[$];
    logic [23:0] got_a[$];
    logic [7:0]  got_d[$];

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_aai = 0; m_wel = 0; m_ebsy = 0; m_incmd = 0;
        end else begin
            if (prog_req && prog_done) begin
                got_a.push_back(prog_addr);
                got_d.push_back(prog_data);
                if (exp_a.size() == 0) chk("R3 unexpected write", 32'(prog_addr), 32'hFFFFFFFF);
                else begin
                    chk("R3 write address", 32'(prog_addr), 32'(exp_a.pop_front()));
                    chk("R3 write data", 32'(prog_data), 32'(exp_d.pop_front()));
                end
            end
            if (op_valid && op_code == 8'h70) m_ebsy = 1;
            else if (op_valid && op_code == 8'h80) m_ebsy = 0;
            if (cs_n) m_incmd = 0; else if (op_valid) m_incmd = 1;
            case (m_ph)
                0: if (op_valid) begin
                    if (op_code == 8'hAD) begin
                        if (m_aai) m_ph = 2; else if (m_wel) m_ph = 1;
                    end else if (op_code == 8'h06) m_wel = 1;
                    else if (op_code == 8'h04) begin m_wel = 0; m_aai = 0; end
                    else if (op_code == 8'h05 && m_aai) begin m_wel = 0; m_aai = 0; end
                end
                1: if (cs_n) m_ph = 0; else if (addr_valid) begin m_word = addr[23:1]; m_ph = 2; end
                2: if (cs_n) m_ph = 0; else if (data_valid) begin m_b0 = data_in; m_ph = 3; end
                3: if (cs_n) m_ph = 0; else if (data_valid) begin
                    m_b1 = data_in; m_aai = 1; m_ph = 4;
                    exp_a.push_back({m_word, 1'b0}); exp_d.push_back(m_b0);
                    exp_a.push_back({m_word, 1'b1}); exp_d.push_back(m_b1);
                end
                4: if (prog_done) m_ph = 5;
                default: if (prog_done) begin m_ph = 0; m_word = m_word + 1; end
            endcase
        end
        if (cyc == 100000 && !finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        #1;
        if (rst_n) begin
            chk("R3 prog_req", 32'(prog_req), 32'(m_ph >= 4));
            if (m_ph >= 4) begin
                chk("R3 prog_addr", 32'(prog_addr), 32'({m_word, m_ph == 5}));
                chk("R3 prog_data", 32'(prog_data), 32'(m_ph == 5 ? m_b1 : m_b0));
            end
            chk("R5 busy", 32'(busy), 32'(m_ph >= 4));
            chk("R8 stat_aai", 32'(stat_aai), 32'(m_aai));
            chk("R6 wel", 32'(wel), 32'(m_wel));
            chk("R7 so_oe", 32'(so_oe), 32'(m_ebsy && m_aai && !cs_n && !m_incmd));
            if (so_oe) chk("R7 so_out", 32'(so_out), 32'(m_ph < 4));
        end
    end

    task automatic send_op(input logic [7:0] c);
        cs_n = 0; op_valid = 1; op_code = c;
        @(negedge clk); op_valid = 0;
    endtask
    task automatic send_addr(input logic [23:0] a);
        addr_valid = 1; addr = a;
        @(negedge clk); addr_valid = 0;
    endtask
    task automatic send_data(input logic [7:0] d);
        data_valid = 1; data_in = d;
        @(negedge clk); data_valid = 0;
    endtask
    task automatic end_cmd();
        cs_n = 1;
        @(negedge clk);
    endtask
    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 prog_req", 32'(prog_req), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 stat_aai", 32'(stat_aai), 0);
        chk("R1 wel", 32'(wel), 0);
        chk("R1 so_oe", 32'(so_oe), 0);
        rst_n = 1;
        @(negedge clk);

        // R2 no write enable
        send_op(8'hAD); send_addr(24'h000100); send_data(8'hEE); send_data(8'hEF); end_cmd();
        repeat (8) @(negedge clk);
        chk("R2 nothing written", 32'(got_a.size()), 0);
        chk("R2 mode stays off", 32'(stat_aai), 0);

        // R3 / R10 / R8 first command at odd address
        send_op(8'h06); end_cmd();
        chk("R3 wel set", 32'(wel), 1);
        send_op(8'hAD); send_addr(24'h012345); send_data(8'hA1);
        chk("R8 flag low before second byte", 32'(stat_aai), 0);
        send_data(8'hB2);
        chk("R8 flag high after second byte", 32'(stat_aai), 1);
        end_cmd(); wait_idle();
        chk("R10 byte0 addr", 32'(got_a[0]), 32'h012344);
        chk("R3 byte0 data", 32'(got_d[0]), 32'hA1);
        chk("R3 byte1 addr", 32'(got_a[1]), 32'h012345);
        chk("R3 byte1 data", 32'(got_d[1]), 32'hB2);

        // R7 ready indication
        send_op(8'h70); end_cmd();
        cs_n = 0; @(negedge clk);
        chk("R7 pin driven when ready", 32'(so_oe), 1);
        chk("R7 ready level", 32'(so_out), 1);

        // R4 continuation, R7 busy level, R5 ignore while busy
        send_op(8'hAD); send_data(8'h11); send_data(8'h22); end_cmd();
        cs_n = 0; @(negedge clk);
        chk("R7 pin driven when busy", 32'(so_oe), 1);
        chk("R7 busy level", 32'(so_out), 0);
        send_op(8'hAD); send_data(8'h99); send_data(8'h9A); end_cmd();
        wait_idle();
        repeat (6) @(negedge clk);
        chk("R5 busy opcode ignored", 32'(got_a.size()), 4);
        chk("R4 next word addr", 32'(got_a[2]), 32'h012346);
        chk("R4 next word data", 32'(got_d[3]), 32'h22);

        // R9 aborted continuation
        send_op(8'hAD); send_data(8'h5A); end_cmd();
        repeat (8) @(negedge clk);
        chk("R9 nothing written", 32'(got_a.size()), 4);
        chk("R9 mode kept", 32'(stat_aai), 1);
        send_op(8'hAD); send_data(8'h33); send_data(8'h44); end_cmd(); wait_idle();
        chk("R4 after abort addr", 32'(got_a[4]), 32'h012348);
        chk("R4 after abort data", 32'(got_d[5]), 32'h44);

        // R7 disable
        send_op(8'h80); end_cmd();
        cs_n = 0; @(negedge clk);
        chk("R7 pin released after DBSY", 32'(so_oe), 0);
        cs_n = 1; @(negedge clk);

        // R6 status read exits
        send_op(8'h05); end_cmd();
        chk("R6 RDSR exits mode", 32'(stat_aai), 0);
        chk("R6 RDSR clears wel", 32'(wel), 0);
        send_op(8'hAD); send_addr(24'h0); send_data(8'h01); send_data(8'h02); end_cmd();
        repeat (8) @(negedge clk);
        chk("R2 ignored after exit", 32'(got_a.size()), 6);

        // R4 carry across boundary, R6 WRDI
        send_op(8'h06); end_cmd();
        send_op(8'hAD); send_addr(24'h00FFFE); send_data(8'h55); send_data(8'h66); end_cmd(); wait_idle();
        send_op(8'hAD); send_data(8'h77); send_data(8'h88); end_cmd(); wait_idle();
        chk("R4 boundary word0", 32'(got_a[7]), 32'h00FFFF);
        chk("R4 carry addr", 32'(got_a[8]), 32'h010000);
        chk("R4 carry data", 32'(got_d[9]), 32'h88);
        send_op(8'h04); end_cmd();
        chk("R6 WRDI exits mode", 32'(stat_aai), 0);
        chk("R6 WRDI clears wel", 32'(wel), 0);
        repeat (4) @(negedge clk);
        chk("R3 all expected writes seen", 32'(exp_a.size()), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule